// File: doc/BRIEF.md
# Fractional Request Pacer

This block generates the pacing strobes that decide when each channel of a transfer engine may move its next data item. A small bank of pacing timers each produce request pulses at an average rate of the clock frequency times X/Y, where X and Y are two 16-bit values loaded together in one write. Because the pulses come from a running remainder rather than a counter that divides by a whole number, any ratio that fits the two fields can be reached. Over any window the number of pulses stays within one of the ideal count.

Every channel has its own 6-bit source code. One code space covers all sources. The lowest codes pick one of the external data-request lines, the next four pick pacing timers 0 to 3, and the top code means the channel is always requested. The timer codes are consecutive, so timer k's code is the first timer code plus k. A build may include fewer than four timers. A code that names a timer the build does not include gives no requests.

Timers and selectors are loaded through plain one-cycle write strobes. The block's outputs are the per-channel request strobes and, for observation, each timer's own pulse.

Top module: `dma_pace_gen`

## Requirements
- R1: While reset is asserted, every timer pulse and every channel request is 0. After reset, every selector holds code 0x3f and every timer holds X = 0 and Y = 0. So in the first cycle after release, every channel request is 1 and no timer pulses.
- R2: A timer write loads X from `tmr_wr_data[31:16]` and Y from `tmr_wr_data[15:0]` into the timer picked by `tmr_wr_idx`, and clears its remainder. The timer does not pulse in the cycle that follows the write edge. A write to an index at or above the number of built timers has no effect.
- R3: When 0 < X < Y, the timer pulses in the k-th cycle after the write exactly when floor(k·X/Y) differs from floor((k−1)·X/Y). After k cycles it has therefore given floor(k·X/Y) pulses.
- R4: A timer whose X is 0 or whose Y is 0 never pulses.
- R5: A timer with X ≥ Y and both values nonzero pulses in every cycle.
- R6: A channel whose code n lies in 0x00 to 0x3a drives its request one cycle after it samples `ext_req[n]`.
- R7: A channel whose code is 0x3b + k, for a built timer k, repeats that timer's pulse one cycle later.
- R8: A channel whose code names a timer that the build does not include never requests.
- R9: A channel with code 0x3f requests in every cycle.
- R10: A selector write to one channel changes that channel's source from the next cycle on. Other channels are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_wr | input | 1 | Timer load strobe |
| tmr_wr_idx | input | 2 | Timer picked by the load |
| tmr_wr_data | input | 32 | X in [31:16], Y in [15:0] |
| sel_wr | input | 1 | Selector load strobe |
| sel_wr_ch | input | CH_W | Channel picked by the selector load |
| sel_wr_code | input | 6 | New source code |
| ext_req | input | 59 | External data-request lines |
| tmr_tick | output | NUM_TIMERS | Pulse of each built timer |
| pace_req | output | NUM_CH | Request strobe of each channel |

## Verification
The assertions assume that X and Y change only through the load strobe. They also assume that a load in one cycle makes the remainder start from zero. Given those, a timer with nonzero Y keeps its remainder below Y and always has a defined output. The random stimulus picks new X/Y pairs from four classes: small fractions, full-range values, a zero numerator and a zero denominator. It also reprograms selectors across external, built-timer, missing-timer and always-on codes. A second instance built with two timers uses the same inputs, so the codes for timers it lacks are exercised as well.

// File: rtl/dma_pace_pkg.sv
package dma_pace_pkg;
  localparam int CODE_W     = 6;
  localparam int CODE_SPACE = 1 << CODE_W;
  localparam int EXT_LINES  = 59;
  localparam int TMR_SLOTS  = 4;
  localparam int TMR_IDX_W  = $clog2(TMR_SLOTS);
  localparam logic [CODE_W-1:0] TMR_CODE0   = CODE_W'(EXT_LINES);
  localparam logic [CODE_W-1:0] ALWAYS_CODE = CODE_W'(CODE_SPACE - 1);
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/dma_pace_timer.sv
module dma_pace_timer #(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FRAC_W-1:0] load_x,
  input  logic [FRAC_W-1:0] load_y,
  output logic              tick
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] x_q, x_d, y_q, y_d, acc_q, acc_d;
  logic [SUM_W-1:0]  sum, diff;
  logic              tick_q, tick_d;

  always_comb begin
    x_d    = x_q;
    y_d    = y_q;
    acc_d  = acc_q;
    tick_d = 1'b0;
    sum    = {1'b0, acc_q} + {1'b0, x_q};
    diff   = sum - {1'b0, y_q};
    if (load) begin
      x_d   = load_x;
      y_d   = load_y;
      acc_d = '0;
    end else if (x_q == '0 || y_q == '0) begin
      acc_d = '0;
    end else if (x_q >= y_q) begin
      tick_d = 1'b1;
      acc_d  = '0;
    end else if (sum >= {1'b0, y_q}) begin
      tick_d = 1'b1;
      acc_d  = diff[FRAC_W-1:0];
    end else begin
      acc_d = sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      x_q    <= x_d;
      y_q    <= y_d;
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R2
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tick_q);
  // R4
  zero_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (x_q == '0 || y_q == '0)) |=> !tick_q);
  // R5
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && x_q != '0 && y_q != '0 && x_q >= y_q) |=> tick_q);
  // R3
  remainder_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_q != '0) |-> (acc_q < y_q));
endmodule

// File: rtl/dma_pace_select.sv
module dma_pace_select
  import dma_pace_pkg::*;
#(
  parameter int NUM_TIMERS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  code_t                 load_code,
  input  logic [CODE_SPACE-1:0] src_vec,
  output logic                  req
);
  localparam int FIRST_ABSENT = int'(TMR_CODE0) + NUM_TIMERS;

  code_t sel_q, sel_d;
  logic  req_q, req_d;

  always_comb begin
    sel_d = load ? load_code : sel_q;
    req_d = src_vec[sel_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= ALWAYS_CODE;
      req_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;

  // R9
  always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == ALWAYS_CODE) |=> req_q);
  // R8
  absent_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_q) >= FIRST_ABSENT && sel_q != ALWAYS_CODE) |=> !req_q);
endmodule

// File: rtl/dma_pace_gen.sv
module dma_pace_gen
  import dma_pace_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int NUM_TIMERS = 4,
  parameter int FRAC_W     = 16,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tmr_wr,
  input  logic [TMR_IDX_W-1:0]  tmr_wr_idx,
  input  logic [2*FRAC_W-1:0]   tmr_wr_data,
  input  logic                  sel_wr,
  input  logic [CH_W-1:0]       sel_wr_ch,
  input  logic [CODE_W-1:0]     sel_wr_code,
  input  logic [EXT_LINES-1:0]  ext_req,
  output logic [NUM_TIMERS-1:0] tmr_tick,
  output logic [NUM_CH-1:0]     pace_req
);
  logic [CODE_SPACE-1:0] src_vec;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    logic hit;
    assign hit = tmr_wr && (tmr_wr_idx == TMR_IDX_W'(t));
    dma_pace_timer #(.FRAC_W(FRAC_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (hit),
      .load_x (tmr_wr_data[2*FRAC_W-1:FRAC_W]),
      .load_y (tmr_wr_data[FRAC_W-1:0]),
      .tick   (tmr_tick[t])
    );
  end

  assign src_vec[EXT_LINES-1:0] = ext_req;
  for (genvar s = 0; s < TMR_SLOTS; s++) begin : g_slot
    if (s < NUM_TIMERS) begin : g_built
      assign src_vec[EXT_LINES+s] = tmr_tick[s];
    end else begin : g_absent
      assign src_vec[EXT_LINES+s] = 1'b0;
    end
  end
  assign src_vec[CODE_SPACE-1] = 1'b1;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = sel_wr && (sel_wr_ch == CH_W'(c));
    dma_pace_select #(.NUM_TIMERS(NUM_TIMERS)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (hit),
      .load_code (sel_wr_code),
      .src_vec   (src_vec),
      .req       (pace_req[c])
    );
  end

  // R7
  timer_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_wr && g_ch[0].u_sel.sel_q == TMR_CODE0) |=> (pace_req[0] == $past(tmr_tick[0])));
endmodule

// File: tb/dma_pace_gen_tb_top.sv
`timescale 1ns/1ps
module dma_pace_gen_tb_top;
  localparam int NCH = 4;
  localparam int NT  = 4;
  localparam int NTS = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tmr_wr;
  logic [1:0]  tmr_wr_idx;
  logic [31:0] tmr_wr_data;
  logic        sel_wr;
  logic [1:0]  sel_wr_ch;
  logic [5:0]  sel_wr_code;
  logic [58:0] ext_req;
  logic [NT-1:0]  tick;
  logic [NCH-1:0] req;
  logic [NTS-1:0] tick_s;
  logic [NCH-1:0] req_s;

  always #2 clk = ~clk;

  dma_pace_gen #(.NUM_CH(NCH), .NUM_TIMERS(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .tmr_wr_idx(tmr_wr_idx),
    .tmr_wr_data(tmr_wr_data), .sel_wr(sel_wr), .sel_wr_ch(sel_wr_ch),
    .sel_wr_code(sel_wr_code), .ext_req(ext_req), .tmr_tick(tick), .pace_req(req));

  dma_pace_gen #(.NUM_CH(NCH), .NUM_TIMERS(NTS)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .tmr_wr_idx(tmr_wr_idx),
    .tmr_wr_data(tmr_wr_data), .sel_wr(sel_wr), .sel_wr_ch(sel_wr_ch),
    .sel_wr_code(sel_wr_code), .ext_req(ext_req), .tmr_tick(tick_s), .pace_req(req_s));

  int n_chk = 0;
  int n_fail = 0;
  bit chk_en = 1'b0;

  int unsigned m_x [NT];
  int unsigned m_y [NT];
  longint      m_k [NT];
  bit          m_tick [NT];
  bit          m_tnew [NT];
  int          m_sel [NCH];
  bit          m_selnew [NCH];
  bit          m_req [NCH];
  bit          m_req_s [NCH];

  function automatic bit tick_at(int unsigned x, int unsigned y, longint k);
    longint lx = longint'(x);
    longint ly = longint'(y);
    if (x == 0 || y == 0) return 1'b0;
    if (x >= y) return 1'b1;
    return ((k * lx) / ly) != (((k - 1) * lx) / ly);
  endfunction

  function automatic bit src_of(int code, int nt);
    if (code < 59) return ext_req[code];
    if (code == 63) return 1'b1;
    if (code - 59 < nt) return m_tick[code-59];
    return 1'b0;
  endfunction

  function automatic string code_tag(int code, int nt);
    if (code < 59) return "R6";
    if (code == 63) return "R9";
    if (code - 59 < nt) return "R7";
    return "R8";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin
        m_x[t] <= 0; m_y[t] <= 0; m_k[t] <= 0; m_tick[t] <= 1'b0; m_tnew[t] <= 1'b0;
      end
      for (int c = 0; c < NCH; c++) begin
        m_sel[c] <= 63; m_selnew[c] <= 1'b0; m_req[c] <= 1'b0; m_req_s[c] <= 1'b0;
      end
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (tmr_wr && int'(tmr_wr_idx) == t) begin
          m_x[t] <= int'(tmr_wr_data[31:16]);
          m_y[t] <= int'(tmr_wr_data[15:0]);
          m_k[t] <= 0; m_tick[t] <= 1'b0; m_tnew[t] <= 1'b1;
        end else begin
          m_k[t] <= m_k[t] + 1;
          m_tick[t] <= tick_at(m_x[t], m_y[t], m_k[t] + 1);
          m_tnew[t] <= 1'b0;
        end
      end
      for (int c = 0; c < NCH; c++) begin
        m_req[c]   <= src_of(m_sel[c], NT);
        m_req_s[c] <= src_of(m_sel[c], NTS);
        if (sel_wr && int'(sel_wr_ch) == c) begin
          m_sel[c] <= int'(sel_wr_code); m_selnew[c] <= 1'b1;
        end else begin
          m_selnew[c] <= 1'b0;
        end
      end
    end
  end

  task automatic check_bit(string tag, string what, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      for (int t = 0; t < NT; t++) begin
        string tg;
        if (m_tnew[t]) tg = "R2";
        else if (m_x[t] == 0 || m_y[t] == 0) tg = "R4";
        else if (m_x[t] >= m_y[t]) tg = "R5";
        else tg = "R3";
        check_bit(tg, $sformatf("tick%0d", t), tick[t], m_tick[t]);
        if (t < NTS) check_bit(tg, $sformatf("small tick%0d", t), tick_s[t], m_tick[t]);
      end
      for (int c = 0; c < NCH; c++) begin
        string tg;
        tg = m_selnew[c] ? "R10" : code_tag(m_sel[c], NT);
        check_bit(tg, $sformatf("req%0d", c), req[c], m_req[c]);
        tg = m_selnew[c] ? "R10" : code_tag(m_sel[c], NTS);
        check_bit(tg, $sformatf("small req%0d", c), req_s[c], m_req_s[c]);
      end
    end
  end

  task automatic idle();
    tmr_wr = 1'b0; sel_wr = 1'b0;
  endtask

  task automatic wr_tmr(int idx, int x, int y);
    tmr_wr = 1'b1; tmr_wr_idx = 2'(idx); tmr_wr_data = {16'(x), 16'(y)};
  endtask

  task automatic wr_sel(int ch, int code);
    sel_wr = 1'b1; sel_wr_ch = 2'(ch); sel_wr_code = 6'(code);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5eed_0a1c);
    rst_n = 1'b0; ext_req = '0; tmr_wr_idx = '0; tmr_wr_data = '0;
    sel_wr_ch = '0; sel_wr_code = '0;
    idle();
    repeat (3) @(negedge clk);
    // R1: outputs held low during reset
    check_bit("R1", "tick during reset", |tick, 1'b0);
    check_bit("R1", "req during reset", |req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: default selector is always-on, timers idle
    check_bit("R1", "req after reset", &req, 1'b1);
    check_bit("R1", "tick after reset", |tick, 1'b0);
    chk_en = 1'b1;

    // Directed corners: R3 1/3, R4 zero X, R5 X==Y, R4 zero Y
    wr_tmr(0, 1, 3); @(negedge clk);
    wr_tmr(1, 0, 5); @(negedge clk);
    wr_tmr(2, 7, 7); @(negedge clk);
    wr_tmr(3, 3, 0); @(negedge clk);
    idle();
    wr_sel(0, 59); @(negedge clk);
    wr_sel(1, 63); @(negedge clk);
    wr_sel(2, 5);  @(negedge clk);
    wr_sel(3, 61); @(negedge clk);
    idle();
    repeat (40) begin ext_req = {$urandom, $urandom}; @(negedge clk); end
    // Near-unity fraction and absent timer codes on the small build (R8)
    wr_tmr(0, 16'hfffe, 16'hffff); @(negedge clk);
    wr_tmr(3, 5, 9); idle(); wr_tmr(3, 5, 9); @(negedge clk);
    idle();
    wr_sel(1, 62); @(negedge clk);
    wr_sel(2, 60); @(negedge clk);
    idle();
    repeat (60) begin ext_req = {$urandom, $urandom}; @(negedge clk); end

    // Constrained random phase
    for (int i = 0; i < 6000; i++) begin
      idle();
      ext_req = {$urandom, $urandom};
      if ($urandom_range(15) == 0) begin
        int y, x;
        case ($urandom_range(3))
          0: begin y = $urandom_range(20, 1); x = $urandom_range(y + 2, 1); end
          1: begin y = $urandom_range(65535); x = $urandom_range(65535); end
          2: begin y = $urandom_range(50, 1); x = 0; end
          default: begin y = 0; x = $urandom_range(30); end
        endcase
        wr_tmr($urandom_range(3), x, y);
      end
      if ($urandom_range(11) == 0) begin
        int code;
        case ($urandom_range(2))
          0: code = $urandom_range(58);
          1: code = $urandom_range(62, 59);
          default: code = 63;
        endcase
        wr_sel($urandom_range(NCH - 1), code);
      end
      @(negedge clk);
    end
    idle();
    repeat (4) @(negedge clk);
    chk_en = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule